// File: doc/BRIEF.md
# Single-Digit Decimal/Binary Multiplier

This block multiplies two 4-bit digits with no clock and no storage. A mode input picks how the operands and the result are read. In binary mode the operands are unsigned values from 0 to 15 and the output is their 8-bit product. In decimal mode the operands are BCD digits and the output packs the product as two BCD digits: the tens digit in the upper nibble and the units digit in the lower nibble.

Of the 256 possible operand pairs, only 100 are legal in decimal mode. The block uses this. When the multiplier digit is 8 or 9, its middle bits are zero, so the product needs only the eight-times multiple plus the operand itself. Every other legal digit needs at most three small shifted multiples. The binary mode sums all four shifted partial products. The binary result is turned into BCD by doubling a digit pair bit by bit, and adding six to the units digit whenever it passes nine. No lookup table and no stored multiples are used.

When either operand is above 9 in decimal mode, the output is zero and an invalid flag is raised.

Top module: `dmul_digit`

## Requirements
- R1: With `hex_mode`=1, `product` equals the unsigned product `mcand`×`mplier` for all 256 operand pairs, in the range 0 to 225.
- R2: With `hex_mode`=1, `invalid` is 0 for every operand pair, including operands 10 to 15.
- R3: With `hex_mode`=0 and both operands 0 to 9, `product[7:4]`×10 + `product[3:0]` equals `mcand`×`mplier`.
- R4: With `hex_mode`=0 and both operands 0 to 9, `product[3:0]` is at most 9 and `product[7:4]` is at most 8. For example, 9×9 gives 8'h81 and 7×8 gives 8'h56.
- R5: With `hex_mode`=0 and either operand above 9, `product` is 8'h00 and `invalid` is 1.
- R6: With `hex_mode`=0 and both operands 0 to 9, `invalid` is 0.
- R7: The outputs depend only on the present inputs. A pair applied again after other pairs gives the same result, and a change on `hex_mode` alone changes the output with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand | input | 4 | First operand digit |
| mplier | input | 4 | Second operand digit; its bit pattern chooses the partial multiples |
| hex_mode | input | 1 | 1: binary product, 0: two-digit BCD product |
| product | output | 8 | Binary product, or tens digit in [7:4] and units digit in [3:0] |
| invalid | output | 1 | Raised in decimal mode when an operand is above 9 |

## Verification
The bench sweeps every operand pair in both modes. This catches an add-six correction that fires at the wrong threshold, which would show up as a units nibble of A to F or a wrong tens digit near products such as 10, 50 and 80. It also catches a shortened decimal sum that drops a multiple, which would give wrong products only for multipliers 8 and 9.

The illegal codes 10 to 15 are applied in both modes. A design that tied the invalid flag to the operand value alone would fail binary mode. A design that let the decimal sum through would return nonzero garbage in decimal mode.

Toggling only the mode between two fixed operands, and replaying earlier pairs later in the sweep, exposes any hidden state or latch.

// File: rtl/dmul_pkg.sv
package dmul_pkg;
    localparam int DIGIT_W = 4;
    localparam int PROD_W  = 2 * DIGIT_W;
    localparam int DEC_MAX = 9;

    typedef struct packed {
        logic [PROD_W-1:0] product;
        logic              invalid;
    } dmul_result_t;
endpackage

// File: rtl/dmul_partial.sv
module dmul_partial #(
    parameter int W = 4
) (
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] full_prod,
    output logic [2*W-1:0] short_prod
);
    localparam int PW = 2 * W;

    logic [W-1:0][PW-1:0] pp;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_pp
            assign pp[gi] = mplier[gi] ? (PW'(mcand) << gi) : '0;
        end
    endgenerate

    // Full array: every shifted multiple summed (binary mode)
    always_comb begin
        full_prod = '0;
        for (int i = 0; i < W; i++) begin
            full_prod = full_prod + pp[i];
        end
    end

    // Decimal short path: a top-bit multiplier digit (8 or 9) has zero
    // middle bits, so only the top multiple plus the operand is needed
    always_comb begin
        short_prod = '0;
        if (mplier[W-1]) begin
            short_prod = pp[W-1] + pp[0];
        end else begin
            for (int i = 0; i < W - 1; i++) begin
                short_prod = short_prod + pp[i];
            end
        end
    end
endmodule

// File: rtl/dmul_bin2bcd.sv
module dmul_bin2bcd #(
    parameter int BIN_W = 8
) (
    input  logic [BIN_W-1:0] bin,
    output logic [3:0]       tens,
    output logic [3:0]       units
);
    logic [4:0] nxt_d;
    logic       carry_d;

    // Shift in one bit per step, MSB first; the units digit doubles and,
    // when it passes nine, takes a plus-six fix that yields the carry
    always_comb begin
        tens    = '0;
        units   = '0;
        nxt_d   = '0;
        carry_d = 1'b0;
        for (int i = BIN_W - 1; i >= 0; i--) begin
            nxt_d   = {units, bin[i]};
            carry_d = 1'b0;
            if (nxt_d > 5'd9) begin
                nxt_d   = nxt_d + 5'd6;
                carry_d = nxt_d[4];
            end
            units = nxt_d[3:0];
            tens  = {tens[2:0], carry_d};
        end
    end
endmodule

// File: rtl/dmul_digit.sv
module dmul_digit
    import dmul_pkg::*;
(
    input  logic [DIGIT_W-1:0] mcand,
    input  logic [DIGIT_W-1:0] mplier,
    input  logic               hex_mode,
    output logic [PROD_W-1:0]  product,
    output logic               invalid
);
    logic [PROD_W-1:0] full_prod;
    logic [PROD_W-1:0] short_prod;
    logic [3:0]        tens;
    logic [3:0]        units;
    logic              bad_digit;
    dmul_result_t      result_d;

    dmul_partial #(.W(DIGIT_W)) u_partial (
        .mcand      (mcand),
        .mplier     (mplier),
        .full_prod  (full_prod),
        .short_prod (short_prod)
    );

    dmul_bin2bcd #(.BIN_W(PROD_W)) u_bcd (
        .bin   (short_prod),
        .tens  (tens),
        .units (units)
    );

    assign bad_digit = (mcand > DIGIT_W'(DEC_MAX)) || (mplier > DIGIT_W'(DEC_MAX));

    always_comb begin
        result_d = '0;
        if (hex_mode) begin
            result_d.product = full_prod;
        end else if (bad_digit) begin
            result_d.invalid = 1'b1;
        end else begin
            result_d.product = {tens, units};
        end
    end

    assign product = result_d.product;
    assign invalid = result_d.invalid;
endmodule

// File: rtl/dmul_digit_chk.sv
module dmul_digit_chk
    import dmul_pkg::*;
(
    input logic [DIGIT_W-1:0] mcand,
    input logic [DIGIT_W-1:0] mplier,
    input logic               hex_mode,
    input logic [PROD_W-1:0]  product,
    input logic               invalid
);
    logic in_range;
    int   arith;
    int   dec_val;

    assign in_range = (mcand <= DIGIT_W'(DEC_MAX)) && (mplier <= DIGIT_W'(DEC_MAX));
    assign arith    = int'(mcand) * int'(mplier);
    assign dec_val  = int'(product[7:4]) * 10 + int'(product[3:0]);

    always_comb begin
        if (hex_mode) begin
            p_hex_exact_r1: assert (int'(product) == arith)
                else $error("hex product mismatch");
            p_hex_no_flag_r2: assert (!invalid)
                else $error("invalid raised in hex mode");
        end else if (in_range) begin
            p_dec_value_r3: assert (dec_val == arith)
                else $error("decimal value mismatch");
            p_dec_digits_r4: assert (product[3:0] <= 4'd9 && product[7:4] <= 4'd8)
                else $error("non-BCD digit");
            p_dec_no_flag_r6: assert (!invalid)
                else $error("invalid raised on legal digits");
        end else begin
            p_bad_zero_r5: assert (invalid && product == '0)
                else $error("illegal digit not forced to zero");
        end
    end
endmodule

bind dmul_digit dmul_digit_chk u_chk (.*);

// File: tb/dmul_digit_test.sv
module dmul_digit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       rst;
    logic [3:0] mcand;
    logic [3:0] mplier;
    logic       hex_mode;
    logic [7:0] product;
    logic       invalid;

    int checks;
    int failures;
    bit done;

    dmul_digit uut (
        .mcand    (mcand),
        .mplier   (mplier),
        .hex_mode (hex_mode),
        .product  (product),
        .invalid  (invalid)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s a=%0d b=%0d hex=%0d actual=%0d expected=%0d",
                     req, mcand, mplier, hex_mode, act, exp);
        end
    endtask

    task automatic apply(input int a, input int b, input bit hm);
        @(negedge clk);
        mcand    = 4'(a);
        mplier   = 4'(b);
        hex_mode = hm;
        #1;
    endtask

    function automatic int dec_expect(input int a, input int b);
        int p;
        p = a * b;
        return ((p / 10) << 4) | (p % 10);
    endfunction

    initial begin
        checks = 0; failures = 0; done = 1'b0;
        rst = 1'b1; mcand = '0; mplier = '0; hex_mode = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #1;
        // Reset state: zero operands give zero, no flag (R3, R6)
        chk("R3 reset", int'(product), 0);
        chk("R6 reset", int'(invalid), 0);

        for (int m = 0; m < 2; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    apply(a, b, m[0]);
                    if (m == 1) begin
                        chk("R1", int'(product), a * b);
                        chk("R2", int'(invalid), 0);
                    end else if (a > 9 || b > 9) begin
                        chk("R5 product", int'(product), 0);
                        chk("R5 flag", int'(invalid), 1);
                    end else begin
                        chk("R3", int'(product[7:4]) * 10 + int'(product[3:0]), a * b);
                        chk("R4", int'(product), dec_expect(a, b));
                        chk("R6", int'(invalid), 0);
                    end
                end
            end
        end

        // Corner values (R4)
        apply(9, 9, 1'b0); chk("R4 9x9", int'(product), 8'h81);
        apply(7, 8, 1'b0); chk("R4 7x8", int'(product), 8'h56);
        apply(5, 2, 1'b0); chk("R4 5x2", int'(product), 8'h10);
        apply(15, 15, 1'b1); chk("R1 15x15", int'(product), 225);

        // Mode toggle alone, no clock edge between (R7)
        mcand = 4'd9; mplier = 4'd9; hex_mode = 1'b1; #1;
        chk("R7 hex", int'(product), 81);
        hex_mode = 1'b0; #1;
        chk("R7 dec", int'(product), 8'h81);
        apply(12, 3, 1'b0); chk("R7 bad", int'(invalid), 1);
        apply(6, 7, 1'b0); chk("R7 replay", int'(product), 8'h42);
        apply(6, 7, 1'b1); chk("R7 replay hex", int'(product), 42);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule